// File: doc/BRIEF.md
# Batched INT8 Dot-Product Engine

This engine scores a stream of stored signed 8-bit vectors against a batch of query vectors held on chip. Every stored vector has 512 elements and arrives as 128-bit beats, each beat holding 16 consecutive elements. Each beat is multiplied lane by lane against the matching slice of every query in the batch, and the products are added into one 32-bit signed accumulator per query. An incoming byte is read once and feeds all the queries, so the input bandwidth needed does not depend on how many queries are batched.

Software first writes the queries through a load port, one beat-wide slice per write. It then starts a run with a vector count. When the last beat of a vector has been taken, every query's output stream presents one record: the score and the index of the vector within the run. The output streams use valid/ready handshakes. When a record from the previous vector is still waiting at the end of the next vector, the engine holds back input until that record has been taken. A one-cycle done pulse ends the run. The batch size is a compile-time parameter with a default of 8.

Top module: `batch_dot_engine`

## Requirements
- R1: After reset, `busy`, `done`, `inReady` and every bit of `outValid` are 0.
- R2: Each record's score is the 32-bit signed sum, over all vector elements, of the product of the signed stored element and the signed element of that stream's query. Accumulators start from zero for every vector.
- R3: Every vector in a run yields exactly one record on each of the K output streams. Within a stream the index counts 0, 1, 2 and so on, and it restarts at 0 in each new run. The K valid flags of a new record set rise together.
- R4: A query write stores `qLoadData` into query `qLoadSel` at beat slot `qLoadAddr`. Byte lane i (bits 8i+7:8i) of slot a holds element 16a+i, and `inData` uses the same lane mapping. Stored queries are kept across runs until they are rewritten.
- R5: Query writes made while `busy` is 1 are ignored.
- R6: `start` is honoured only while `busy` is 0, and `vecCount` is captured at that moment. A `start` or a changed `vecCount` during a run has no effect. `inReady` is 0 whenever `busy` is 0.
- R7: A record that is presented but not taken keeps its valid flag, score and index unchanged. If any record is still pending when the last beat of the next vector is offered, `inReady` is 0 for that beat. No record is lost.
- R8: When all output streams are ready and input is offered on every cycle, `inReady` never drops during a run, so one beat is taken per clock and a vector takes 32 cycles.
- R9: `done` is a one-cycle pulse in the cycle after the last record of the run is taken, and `busy` is 0 from that cycle on. A start with `vecCount` 0 gives the pulse in the cycle after the start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (honoured while idle) |
| vecCount | input | IDX_W | Number of vectors in the run |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| qLoadValid | input | 1 | Query write strobe |
| qLoadSel | input | QSEL_W | Query number to write |
| qLoadAddr | input | BEAT_IDX_W | Beat slot within the query |
| qLoadData | input | 128 | Sixteen query elements |
| inValid | input | 1 | Input beat valid |
| inReady | output | 1 | Input beat accepted when high with inValid |
| inData | input | 128 | Sixteen stored-vector elements |
| outValid | output | NUM_QUERIES | Record valid, one per query |
| outReady | input | NUM_QUERIES | Record taken, one per query |
| outScore | output | NUM_QUERIES*32 | Scores, query k at bits 32k+31:32k |
| outIndex | output | NUM_QUERIES*IDX_W | Vector index per query stream |

## Verification
The bench builds the engine with three queries, 64-element vectors (four beats each) and 8-bit indices. Short vectors bring the last-beat stall, run boundaries and index restarts within a few cycles of each other. A batch size that is not a power of two exercises query selection with unused codes. Random per-stream ready patterns and gaps in the input stress independent draining of the streams. Directed runs cover a full stall, extreme-magnitude elements, misuse while busy and an empty run.

// File: rtl/batch_dot_pkg.sv
package batch_dot_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } engState_t;

  // strobes from control to datapath, valid for the current cycle
  typedef struct packed {
    logic runStart;  // a run begins: clear accumulators
    logic beatFire;  // an input beat is accepted
    logic vecEnd;    // the accepted beat closes a vector
    logic qWrite;    // a query write is allowed
  } engStrobe_t;

endpackage

// File: rtl/batch_dot_ctrl.sv
module batch_dot_ctrl
  import batch_dot_pkg::*;
#(
  parameter int BEATS = 32,
  parameter int IDX_W = 16,
  localparam int BEAT_IDX_W = $clog2(BEATS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [IDX_W-1:0]      vecCount,
  input  logic                  qLoadValid,
  input  logic                  inValid,
  input  logic                  slotsFree,
  output logic                  inReady,
  output logic                  busy,
  output logic                  done,
  output engStrobe_t            strobes,
  output logic [BEAT_IDX_W-1:0] beatIdx,
  output logic [IDX_W-1:0]      vecIdx
);

  engState_t             state;
  logic [BEAT_IDX_W-1:0] beatCnt;
  logic [IDX_W-1:0]      vecLast;
  logic                  lastBeat;
  logic                  idle;

  assign idle     = (state == ST_IDLE);
  assign lastBeat = (beatCnt == BEAT_IDX_W'(BEATS - 1));
  // a closing beat may only enter when every output slot can take a new record
  assign inReady  = (state == ST_RUN) && (!lastBeat || slotsFree);
  assign busy     = !idle;
  assign beatIdx  = beatCnt;

  always_comb begin
    strobes.runStart = start && idle;
    strobes.beatFire = inValid && inReady;
    strobes.vecEnd   = inValid && inReady && lastBeat;
    strobes.qWrite   = qLoadValid && idle;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      beatCnt <= '0;
      vecIdx  <= '0;
      vecLast <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            beatCnt <= '0;
            vecIdx  <= '0;
            vecLast <= vecCount - IDX_W'(1);
            if (vecCount == '0) done  <= 1'b1;
            else                state <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (strobes.beatFire) begin
            beatCnt <= lastBeat ? '0 : beatCnt + BEAT_IDX_W'(1);
          end
          if (strobes.vecEnd) begin
            if (vecIdx == vecLast) state  <= ST_DRAIN;
            else                   vecIdx <= vecIdx + IDX_W'(1);
          end
        end
        ST_DRAIN: begin
          if (slotsFree) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/batch_dot_lanes.sv
module batch_dot_lanes
  import batch_dot_pkg::*;
#(
  parameter int NUM_QUERIES = 8,
  parameter int LANES       = 16,
  parameter int BEATS       = 32,
  parameter int ACC_W       = 32,
  parameter int IDX_W       = 16,
  localparam int BEAT_W     = LANES * 8,
  localparam int BEAT_IDX_W = $clog2(BEATS),
  localparam int QSEL_W     = (NUM_QUERIES > 1) ? $clog2(NUM_QUERIES) : 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  engStrobe_t                   strobes,
  input  logic [BEAT_IDX_W-1:0]        beatIdx,
  input  logic [IDX_W-1:0]             vecIdx,
  input  logic [QSEL_W-1:0]            qLoadSel,
  input  logic [BEAT_IDX_W-1:0]        qLoadAddr,
  input  logic [BEAT_W-1:0]            qLoadData,
  input  logic [BEAT_W-1:0]            inData,
  input  logic [NUM_QUERIES-1:0]       outReady,
  output logic [NUM_QUERIES-1:0]       outValid,
  output logic [NUM_QUERIES*ACC_W-1:0] outScore,
  output logic [NUM_QUERIES*IDX_W-1:0] outIndex,
  output logic                         slotsFree
);

  // sum of the lane products of one beat against one query slice
  function automatic logic signed [ACC_W-1:0] beatDot(input logic [BEAT_W-1:0] x,
                                                      input logic [BEAT_W-1:0] y);
    logic signed [ACC_W-1:0] sum;
    logic signed [15:0]      prod;
    sum = '0;
    for (int i = 0; i < LANES; i++) begin
      prod = 16'($signed(x[8*i +: 8])) * 16'($signed(y[8*i +: 8]));
      sum  = sum + ACC_W'(prod);
    end
    return sum;
  endfunction

  assign slotsFree = &(~outValid | outReady);

  for (genvar k = 0; k < NUM_QUERIES; k++) begin : g_query
    logic [BEAT_W-1:0]       qBank [BEATS];
    logic [BEAT_W-1:0]       qWord;
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] dot;
    logic signed [ACC_W-1:0] scoreReg;
    logic [IDX_W-1:0]        idxReg;
    logic                    validReg;
    logic                    qWe;

    assign qWe = strobes.qWrite && (qLoadSel == QSEL_W'(k));

    always_ff @(posedge clk) begin
      if (qWe) qBank[qLoadAddr] <= qLoadData;
    end

    assign qWord = qBank[beatIdx];
    assign dot   = beatDot(inData, qWord);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        acc      <= '0;
        scoreReg <= '0;
        idxReg   <= '0;
        validReg <= 1'b0;
      end else begin
        if (strobes.runStart) begin
          acc <= '0;
        end else if (strobes.vecEnd) begin
          scoreReg <= acc + dot;
          idxReg   <= vecIdx;
          acc      <= '0;
        end else if (strobes.beatFire) begin
          acc <= acc + dot;
        end

        if (strobes.vecEnd)   validReg <= 1'b1;
        else if (outReady[k]) validReg <= 1'b0;
      end
    end

    assign outValid[k]                  = validReg;
    assign outScore[k*ACC_W +: ACC_W]   = scoreReg;
    assign outIndex[k*IDX_W +: IDX_W]   = idxReg;
  end

endmodule

// File: rtl/batch_dot_engine.sv
module batch_dot_engine
  import batch_dot_pkg::*;
#(
  parameter int NUM_QUERIES = 8,
  parameter int VEC_LEN     = 512,
  parameter int LANES       = 16,
  parameter int ACC_W       = 32,
  parameter int IDX_W       = 16,
  localparam int BEAT_W     = LANES * 8,
  localparam int BEATS      = VEC_LEN / LANES,
  localparam int BEAT_IDX_W = $clog2(BEATS),
  localparam int QSEL_W     = (NUM_QUERIES > 1) ? $clog2(NUM_QUERIES) : 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         start,
  input  logic [IDX_W-1:0]             vecCount,
  output logic                         busy,
  output logic                         done,
  input  logic                         qLoadValid,
  input  logic [QSEL_W-1:0]            qLoadSel,
  input  logic [BEAT_IDX_W-1:0]        qLoadAddr,
  input  logic [BEAT_W-1:0]            qLoadData,
  input  logic                         inValid,
  output logic                         inReady,
  input  logic [BEAT_W-1:0]            inData,
  output logic [NUM_QUERIES-1:0]       outValid,
  input  logic [NUM_QUERIES-1:0]       outReady,
  output logic [NUM_QUERIES*ACC_W-1:0] outScore,
  output logic [NUM_QUERIES*IDX_W-1:0] outIndex
);

  engStrobe_t            strobes;
  logic [BEAT_IDX_W-1:0] beatIdx;
  logic [IDX_W-1:0]      vecIdx;
  logic                  slotsFree;

  batch_dot_ctrl #(
    .BEATS (BEATS),
    .IDX_W (IDX_W)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .vecCount   (vecCount),
    .qLoadValid (qLoadValid),
    .inValid    (inValid),
    .slotsFree  (slotsFree),
    .inReady    (inReady),
    .busy       (busy),
    .done       (done),
    .strobes    (strobes),
    .beatIdx    (beatIdx),
    .vecIdx     (vecIdx)
  );

  batch_dot_lanes #(
    .NUM_QUERIES (NUM_QUERIES),
    .LANES       (LANES),
    .BEATS       (BEATS),
    .ACC_W       (ACC_W),
    .IDX_W       (IDX_W)
  ) i_lanes (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .beatIdx   (beatIdx),
    .vecIdx    (vecIdx),
    .qLoadSel  (qLoadSel),
    .qLoadAddr (qLoadAddr),
    .qLoadData (qLoadData),
    .inData    (inData),
    .outReady  (outReady),
    .outValid  (outValid),
    .outScore  (outScore),
    .outIndex  (outIndex),
    .slotsFree (slotsFree)
  );

endmodule

// File: rtl/batch_dot_checker.sv
module batch_dot_checker #(
  parameter int K     = 8,
  parameter int ACC_W = 32,
  parameter int IDX_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               inReady,
  input logic               busy,
  input logic               done,
  input logic [K-1:0]       outValid,
  input logic [K-1:0]       outReady,
  input logic [K*ACC_W-1:0] outScore,
  input logic [K*IDX_W-1:0] outIndex
);

  for (genvar k = 0; k < K; k++) begin : g_stream
    assert_held_record_R7: assert property (@(posedge clk) disable iff (!rstN)
      (outValid[k] && !outReady[k]) |=>
        (outValid[k] && $stable(outScore[k*ACC_W +: ACC_W]) && $stable(outIndex[k*IDX_W +: IDX_W])));
  end

  assert_records_together_R3: assert property (@(posedge clk) disable iff (!rstN)
    (|(outValid & ~$past(outValid))) |-> (&outValid));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_drained_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (outValid == '0 && !busy));

  assert_ready_only_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> busy);

endmodule

bind batch_dot_engine batch_dot_checker #(
  .K     (NUM_QUERIES),
  .ACC_W (ACC_W),
  .IDX_W (IDX_W)
) i_checker (
  .clk      (clk),
  .rstN     (rstN),
  .inReady  (inReady),
  .busy     (busy),
  .done     (done),
  .outValid (outValid),
  .outReady (outReady),
  .outScore (outScore),
  .outIndex (outIndex)
);

// File: tb/test_batch_dot_engine.sv
`timescale 1ns/1ps
module test_batch_dot_engine;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = CLK_PERIOD / 2;
  localparam int K          = 3;
  localparam int VEC_LEN    = 64;
  localparam int LANES      = 16;
  localparam int ACC_W      = 32;
  localparam int IDX_W      = 8;
  localparam int BW         = LANES * 8;
  localparam int BEATS      = VEC_LEN / LANES;
  localparam int BIW        = $clog2(BEATS);
  localparam int QSW        = $clog2(K);
  localparam int MAXV       = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [IDX_W-1:0] vecCount = '0;
  logic             busy, done;
  logic             qLoadValid = 1'b0;
  logic [QSW-1:0]   qLoadSel = '0;
  logic [BIW-1:0]   qLoadAddr = '0;
  logic [BW-1:0]    qLoadData = '0;
  logic             inValid = 1'b0;
  logic             inReady;
  logic [BW-1:0]    inData = '0;
  logic [K-1:0]     outValid;
  logic [K-1:0]     outReady = '0;
  logic [K*ACC_W-1:0] outScore;
  logic [K*IDX_W-1:0] outIndex;

  always #(HALF) clk = ~clk;

  batch_dot_engine #(
    .NUM_QUERIES (K),
    .VEC_LEN     (VEC_LEN),
    .LANES       (LANES),
    .ACC_W       (ACC_W),
    .IDX_W       (IDX_W)
  ) i_batch_dot_engine (
    .clk(clk), .rstN(rstN), .start(start), .vecCount(vecCount), .busy(busy), .done(done),
    .qLoadValid(qLoadValid), .qLoadSel(qLoadSel), .qLoadAddr(qLoadAddr), .qLoadData(qLoadData),
    .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outScore(outScore), .outIndex(outIndex)
  );

  logic [BW-1:0]    qModel [K][BEATS];
  logic [BW-1:0]    vecMem [MAXV][BEATS];
  int               rcvCnt [K];
  logic             heldPrev [K];
  logic [ACC_W-1:0] heldScore [K];
  int doneCnt = 0;
  int readyMode = 0;
  int beatsAccepted = 0;
  int stallCnt = 0;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishUp();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // reference score from the lane mapping of R4 and the arithmetic of R2
  function automatic int expScore(input int k, input int v);
    int acc = 0;
    byte a, b;
    for (int bt = 0; bt < BEATS; bt++)
      for (int i = 0; i < LANES; i++) begin
        a = vecMem[v][bt][8*i +: 8];
        b = qModel[k][bt][8*i +: 8];
        acc += int'(a) * int'(b);
      end
    return acc;
  endfunction

  function automatic logic [BW-1:0] randBeat();
    logic [BW-1:0] r;
    for (int w = 0; w < BW / 32; w++) r[32*w +: 32] = $urandom();
    return r;
  endfunction

  // output side: drive readies after the falling edge, sample just before the rising edge
  initial begin
    for (int k = 0; k < K; k++) begin heldPrev[k] = 0; heldScore[k] = '0; rcvCnt[k] = 0; end
    forever begin
      @(negedge clk);
      for (int k = 0; k < K; k++) begin
        case (readyMode)
          0: outReady[k] = 1'b1;
          1: outReady[k] = ($urandom() % 3) != 0;
          default: outReady[k] = 1'b0;
        endcase
      end
      #(HALF - 1);
      if (rstN) begin
        for (int k = 0; k < K; k++) begin
          if (heldPrev[k])
            check(outValid[k] && outScore[k*ACC_W +: ACC_W] == heldScore[k], "R7",
                  "held record changed", longint'($signed(outScore[k*ACC_W +: ACC_W])),
                  longint'($signed(heldScore[k])));
          if (outValid[k] && outReady[k]) begin
            if (rcvCnt[k] < MAXV) begin
              check($signed(outScore[k*ACC_W +: ACC_W]) == expScore(k, rcvCnt[k]), "R2",
                    "score", longint'($signed(outScore[k*ACC_W +: ACC_W])),
                    longint'(expScore(k, rcvCnt[k])));
              check(int'(outIndex[k*IDX_W +: IDX_W]) == rcvCnt[k], "R3", "index",
                    longint'(outIndex[k*IDX_W +: IDX_W]), longint'(rcvCnt[k]));
            end
            rcvCnt[k]++;
          end
          heldPrev[k]  = outValid[k] && !outReady[k];
          heldScore[k] = outScore[k*ACC_W +: ACC_W];
        end
        if (done) doneCnt++;
      end
    end
  end

  task automatic loadQueries(input bit corner);
    for (int k = 0; k < K; k++)
      for (int b = 0; b < BEATS; b++) begin
        @(negedge clk);
        qLoadValid = 1'b1;
        qLoadSel   = QSW'(k);
        qLoadAddr  = BIW'(b);
        if (corner && k == 0)      qLoadData = {LANES{8'h80}};
        else if (corner && k == 1) qLoadData = {LANES{8'h7F}};
        else                       qLoadData = randBeat();
        qModel[k][b] = qLoadData;
      end
    @(negedge clk);
    qLoadValid = 1'b0;
  endtask

  // called at a falling edge; offers n vectors of beats
  task automatic driveBeats(input int n, input bit gaps, input bit misuse);
    int b = 0;
    while (b < n * BEATS) begin
      inValid = gaps ? (($urandom() % 4) != 0) : 1'b1;
      inData  = vecMem[b / BEATS][b % BEATS];
      if (misuse && b == BEATS + 1) begin
        qLoadValid = 1'b1; qLoadSel = '0; qLoadAddr = '0; qLoadData = '1;
        start = 1'b1; vecCount = IDX_W'(1);
      end else begin
        qLoadValid = 1'b0; start = 1'b0;
      end
      #(HALF - 1);
      if (inValid && !inReady) stallCnt++;
      if (inValid && inReady) begin b++; beatsAccepted++; end
      @(negedge clk);
    end
    inValid = 1'b0; qLoadValid = 1'b0; start = 1'b0;
  endtask

  task automatic runVec(input int n, input int mode, input bit gaps, input bit misuse,
                        input bit stall, input bit cornerVec);
    int t = 0;
    for (int v = 0; v < n; v++)
      for (int b = 0; b < BEATS; b++)
        vecMem[v][b] = (cornerVec && v == 0) ? {LANES{8'h80}} : randBeat();
    readyMode = stall ? 2 : mode;
    @(negedge clk);
    for (int k = 0; k < K; k++) rcvCnt[k] = 0;
    doneCnt = 0; beatsAccepted = 0; stallCnt = 0;
    start = 1'b1; vecCount = IDX_W'(n);
    @(negedge clk);
    start = 1'b0;
    if (stall) begin
      fork
        driveBeats(n, gaps, misuse);
        begin
          repeat (30) @(negedge clk);
          // R7: first vector completes, the second stops before its closing beat
          check(beatsAccepted == 2 * BEATS - 1, "R7", "beats taken while outputs blocked",
                beatsAccepted, 2 * BEATS - 1);
          readyMode = mode;
        end
      join
    end else begin
      driveBeats(n, gaps, misuse);
    end
    if (!gaps && mode == 0 && !stall)
      check(stallCnt == 0, "R8", "input stall cycles with free outputs", stallCnt, 0);
    while (doneCnt == 0 && t < 3000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    check(doneCnt == 1, "R9", "done pulses in run", doneCnt, 1);
    check(busy == 1'b0, "R9", "busy after done", busy, 0);
    for (int k = 0; k < K; k++)
      check(rcvCnt[k] == n, "R3", "records per stream (R6 count kept)", rcvCnt[k], n);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #(HALF - 1);
    check(busy == 1'b0 && done == 1'b0, "R1", "busy/done after reset", {busy, done}, 0);
    check(inReady == 1'b0, "R1", "inReady after reset", inReady, 0);
    check(outValid == '0, "R1", "outValid after reset", outValid, 0);
    @(negedge clk);
    rstN = 1'b1;

    loadQueries(1'b1);
    // R2 R4 R8: extreme elements, free outputs, continuous input
    runVec(3, 0, 1'b0, 1'b0, 1'b0, 1'b1);
    // R5 R6: misuse while busy, random readies and input gaps
    runVec(5, 1, 1'b1, 1'b1, 1'b0, 1'b0);
    // R7: all outputs blocked for a while
    runVec(3, 0, 1'b0, 1'b0, 1'b1, 1'b0);

    loadQueries(1'b0);
    // R4: queries persist across several runs, R3 index restarts each run
    for (int r = 0; r < 5; r++)
      runVec(1 + int'($urandom() % 6), 1, r[0], 1'b0, 1'b0, 1'b0);
    runVec(4, 0, 1'b0, 1'b0, 1'b0, 1'b0);

    // R9: empty run
    @(negedge clk);
    doneCnt = 0;
    start = 1'b1; vecCount = '0;
    @(negedge clk);
    start = 1'b0;
    #(HALF - 1);
    check(done == 1'b1, "R9", "done after empty start", done, 1);
    check(busy == 1'b0, "R9", "busy on empty run", busy, 0);
    repeat (3) @(negedge clk);
    check(doneCnt == 1, "R9", "pulses on empty run", doneCnt, 1);

    finishUp();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R9 watchdog: run finished 0 expected 1");
    finishUp();
  end

endmodule